// File: doc/BRIEF.md
# Windowed Sag and Fault Detector

This block watches one channel of signed samples that arrive one per sample tick. Each sample is reduced to its magnitude and compared against a programmable threshold. Across a window of a programmable number of ticks, the block keeps two tallies: samples whose magnitude lies under the threshold, and samples at or over it. When the window closes, the block raises a sticky flag if the under-threshold tally is strictly larger than the other one. Voltage sag and current fault monitoring use the same block, each instance with its own threshold and window length.

A window length of zero turns detection off, and zero is the value the length takes after reset. Writing a different length abandons the window in progress and starts a fresh one. The flag stays high until the clear input is pulsed. A one-cycle strobe marks every window close, whether or not the flag was set.

Top module: `sagdet_top`

## Requirements
- R1: While reset is active and in the first cycle after it, `flag` and `win_done` are both 0.
- R2: A sample is compared by its magnitude, so a large negative sample (including the most negative code, of magnitude 2^(SMP_W-1)) counts as at or over the threshold.
- R3: A sample whose magnitude equals `level` counts as at or over the threshold, not under it.
- R4: At a window close, `flag` becomes 1 only when the under-threshold count is strictly larger than the at-or-over count; a tie leaves it unchanged.
- R5: With `duration` = N > 0, a window closes on the N-th accepted tick; `win_done` is high for the single cycle after the clock edge that accepts that tick, and 0 after earlier ticks of the window.
- R6: While `duration` is 0, `win_done` stays 0 and no tick can set `flag`.
- R7: Once set, `flag` stays 1 until a cycle with `clr_flag` = 1, after which it reads 0.
- R8: When `clr_flag` is high in the same cycle as a window close that sets the flag, the set wins and `flag` reads 1.
- R9: Both tallies start from zero at every window; counts never carry into the next window.
- R10: A cycle in which `duration` differs from its value in the previous cycle restarts the window; a tick in that cycle is discarded and the next window closes after N further ticks.
- R11: Cycles with `smp_tick` = 0 are not counted and do not advance the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_tick | input | 1 | Sample valid, one cycle per sample |
| smp_data | input | SMP_W | Signed two's-complement sample |
| level | input | SMP_W | Unsigned magnitude threshold |
| duration | input | DUR_W | Window length in ticks; 0 disables |
| clr_flag | input | 1 | Clears the sticky flag |
| flag | output | 1 | Sticky sag/fault indication |
| win_done | output | 1 | One-cycle strobe at each window close |

## Verification
Two functions can land on one clock edge: a window close that sets the flag and a software clear of that flag. The bench drives the last tick of an under-threshold-majority window in the very cycle `clr_flag` is high, then samples `flag` after the edge and expects 1, since a set must not be lost; a following clear alone must then bring it to 0. A second overlap, a length change arriving with a tick, is provoked the same way and judged by when the next strobe appears.

// File: rtl/sagdet_pkg.sv
package sagdet_pkg;

    // Classification of one sample against the threshold.
    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_UNDER = 2'd1,
        CLS_OVER  = 2'd2
    } smp_cls_e;

endpackage

// File: rtl/sagdet_rect.sv
module sagdet_rect
    import sagdet_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic             tick_i,
    input  logic [SMP_W-1:0] data_i,
    input  logic [SMP_W-1:0] level_i,
    output smp_cls_e         cls_o
);

    logic [SMP_W-1:0] mag;

    always_comb begin
        // Magnitude: the most negative code maps to 2^(SMP_W-1), which fits unsigned.
        if (data_i[SMP_W-1]) begin
            mag = (~data_i) + 1'b1;
        end else begin
            mag = data_i;
        end

        if (!tick_i) begin
            cls_o = CLS_NONE;
        end else if (mag < level_i) begin
            cls_o = CLS_UNDER;
        end else begin
            cls_o = CLS_OVER;
        end
    end

endmodule

// File: rtl/sagdet_window.sv
module sagdet_window #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [DUR_W-1:0] duration_i,
    output logic             clear_o,
    output logic             take_o,
    output logic             last_o
);

    typedef struct packed {
        logic [DUR_W-1:0] dur;
        logic [DUR_W-1:0] pos;
    } win_state_t;

    win_state_t st_d, st_q;
    logic       restart;
    logic       enabled;

    always_comb begin
        restart = (duration_i != st_q.dur);
        enabled = (st_q.dur != '0);
        clear_o = restart || !enabled;
        take_o  = tick_i && !clear_o;
        last_o  = take_o && (st_q.pos == st_q.dur - 1'b1);

        st_d     = st_q;
        st_d.dur = duration_i;
        if (clear_o || last_o) begin
            st_d.pos = '0;
        end else if (take_o) begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sagdet_vote.sv
module sagdet_vote
    import sagdet_pkg::*;
#(
    parameter int DUR_W = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear_i,
    input  logic     take_i,
    input  logic     last_i,
    input  smp_cls_e cls_i,
    output logic     under_wins_o
);

    localparam int CW = DUR_W + 1;

    typedef struct packed {
        logic [DUR_W-1:0] under;
        logic [DUR_W-1:0] over;
    } vote_state_t;

    vote_state_t st_d, st_q;
    logic        inc_under;
    logic        inc_over;
    logic [CW-1:0] tot_under;
    logic [CW-1:0] tot_over;

    always_comb begin
        inc_under = take_i && (cls_i == CLS_UNDER);
        inc_over  = take_i && (cls_i == CLS_OVER);
        tot_under = {1'b0, st_q.under} + CW'(inc_under);
        tot_over  = {1'b0, st_q.over}  + CW'(inc_over);
        under_wins_o = tot_under > tot_over;

        st_d = st_q;
        if (clear_i || last_i) begin
            st_d = '0;
        end else begin
            st_d.under = tot_under[DUR_W-1:0];
            st_d.over  = tot_over[DUR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sagdet_top.sv
module sagdet_top
    import sagdet_pkg::*;
#(
    parameter int SMP_W = 16,
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_tick,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [SMP_W-1:0] level,
    input  logic [DUR_W-1:0] duration,
    input  logic             clr_flag,
    output logic             flag,
    output logic             win_done
);

    typedef struct packed {
        logic flag;
        logic done;
    } out_state_t;

    out_state_t st_d, st_q;
    smp_cls_e   cls;
    logic       win_clear;
    logic       win_take;
    logic       win_last;
    logic       under_wins;

    sagdet_rect #(.SMP_W(SMP_W)) u_rect (
        .tick_i  (smp_tick),
        .data_i  (smp_data),
        .level_i (level),
        .cls_o   (cls)
    );

    sagdet_window #(.DUR_W(DUR_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (smp_tick),
        .duration_i (duration),
        .clear_o    (win_clear),
        .take_o     (win_take),
        .last_o     (win_last)
    );

    sagdet_vote #(.DUR_W(DUR_W)) u_vote (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (win_clear),
        .take_i       (win_take),
        .last_i       (win_last),
        .cls_i        (cls),
        .under_wins_o (under_wins)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = win_last;
        // A set at a window close takes priority over a clear.
        if (win_last && under_wins) begin
            st_d.flag = 1'b1;
        end else if (clr_flag) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag     = st_q.flag;
    assign win_done = st_q.done;

endmodule

// File: rtl/sagdet_chk.sv
module sagdet_chk #(
    parameter int SMP_W = 16,
    parameter int DUR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_tick,
    input logic [SMP_W-1:0] smp_data,
    input logic [DUR_W-1:0] duration,
    input logic             clr_flag,
    input logic             flag,
    input logic             win_done
);

    // R4: the flag can only rise together with a window-close strobe.
    a_r4_rise_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> win_done);

    // R5: a close strobe always follows an edge that accepted a tick.
    a_r5_done_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(smp_tick));

    // R6: a zero length in the previous cycle yields no strobe.
    a_r6_off_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(duration) == '0) |-> !win_done);

    // R7: without a clear the flag holds.
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_flag) |=> flag);

    // R8: a clear empties the flag unless a close set it on the same edge.
    a_r8_clear_or_set: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && flag) |=> (!flag || win_done));

    // R10: a changed length never closes a window on that edge.
    a_r10_change_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (duration != $past(duration)) |=> !win_done);

endmodule

bind sagdet_top sagdet_chk #(.SMP_W(SMP_W), .DUR_W(DUR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_tick (smp_tick),
    .smp_data (smp_data),
    .duration (duration),
    .clr_flag (clr_flag),
    .flag     (flag),
    .win_done (win_done)
);

// File: tb/sagdet_top_tb.sv
module sagdet_top_tb;

    localparam int SMP_W = 16;
    localparam int DUR_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_tick = 1'b0;
    logic [SMP_W-1:0] smp_data = '0;
    logic [SMP_W-1:0] level = 16'd100;
    logic [DUR_W-1:0] duration = '0;
    logic             clr_flag = 1'b0;
    logic             flag;
    logic             win_done;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    sagdet_top #(.SMP_W(SMP_W), .DUR_W(DUR_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_tick (smp_tick),
        .smp_data (smp_data),
        .level    (level),
        .duration (duration),
        .clr_flag (clr_flag),
        .flag     (flag),
        .win_done (win_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One tick, then sample outputs at the following falling edge.
    task automatic tick(input logic signed [SMP_W-1:0] s, input logic clr = 1'b0);
        @(negedge clk);
        smp_tick = 1'b1;
        smp_data = s;
        clr_flag = clr;
        @(negedge clk);
        smp_tick = 1'b0;
        clr_flag = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic win4(input string req, input logic signed [SMP_W-1:0] a, b, c, d,
                        input logic exp_flag);
        tick(a); check({req, " done early 1"}, win_done, 0);
        tick(b); check({req, " done early 2"}, win_done, 0);
        tick(c); check({req, " done early 3"}, win_done, 0);
        tick(d); check({req, " done at close"}, win_done, 1);
        check({req, " flag"}, flag, exp_flag);
    endtask

    task automatic t_reset();
        idle(2);
        check("R1 flag in reset", flag, 0);
        check("R1 done in reset", win_done, 0);
        rst_n = 1'b1;
        idle(1);
        check("R1 flag after reset", flag, 0);
        check("R1 done after reset", win_done, 0);
    endtask

    task automatic t_disabled();
        for (int i = 0; i < 6; i++) begin
            tick(16'sd5);
            check("R6 no done when off", win_done, 0);
        end
        check("R6 flag when off", flag, 0);
    endtask

    task automatic set_len(input logic [DUR_W-1:0] n);
        @(negedge clk);
        duration = n;
        idle(2);
    endtask

    task automatic t_tie();
        win4("R5 R4 tie", 16'sd10, 16'sd20, 16'sd200, 16'sd300, 1'b0);
    endtask

    task automatic t_equal();
        win4("R3 equal counts over", -16'sd50, -16'sd150, 16'sd100, 16'sd5, 1'b0);
    endtask

    task automatic t_rectify();
        win4("R2 magnitude", -16'sd300, -16'sd400, 16'sh8000, 16'sd10, 1'b0);
    endtask

    task automatic t_gaps();
        tick(16'sd1); idle(5);
        check("R11 idle not counted 1", win_done, 0);
        tick(16'sd2); idle(3);
        tick(16'sd3); idle(4);
        check("R11 idle not counted 2", win_done, 0);
        tick(16'sd400);
        check("R11 close on 4th tick", win_done, 1);
        check("R4 majority sets flag", flag, 1);
    endtask

    task automatic t_sticky();
        idle(10);
        check("R7 flag holds idle", flag, 1);
        win4("R7 holds over window", 16'sd500, 16'sd600, 16'sd700, 16'sd800, 1'b1);
        @(negedge clk); clr_flag = 1'b1;
        @(negedge clk); clr_flag = 1'b0;
        check("R7 cleared", flag, 0);
    endtask

    task automatic t_fresh_counts();
        win4("R9 set window", 16'sd1, 16'sd2, 16'sd3, 16'sd400, 1'b1);
        @(negedge clk); clr_flag = 1'b1;
        @(negedge clk); clr_flag = 1'b0;
        check("R9 cleared", flag, 0);
        win4("R9 counts restart", 16'sd5, 16'sd6, 16'sd200, 16'sd300, 1'b0);
    endtask

    task automatic t_collide();
        tick(16'sd1); tick(16'sd2); tick(16'sd3);
        tick(16'sd4, 1'b1);
        check("R8 close strobe", win_done, 1);
        check("R8 set beats clear", flag, 1);
        @(negedge clk); clr_flag = 1'b1;
        @(negedge clk); clr_flag = 1'b0;
        check("R8 clear alone", flag, 0);
    endtask

    task automatic t_restart();
        tick(16'sd1); tick(16'sd2); tick(16'sd3);
        // Length change in the same cycle as a tick.
        @(negedge clk);
        duration = 16'd5;
        smp_tick = 1'b1;
        smp_data = 16'sd7;
        @(negedge clk);
        smp_tick = 1'b0;
        check("R10 no close on change", win_done, 0);
        tick(16'sd500); tick(16'sd600); tick(16'sd700);
        tick(16'sd8);
        check("R10 tick in change cycle discarded", win_done, 0);
        tick(16'sd9);
        check("R10 close after 5 new ticks", win_done, 1);
        check("R10 old counts dropped", flag, 0);
    endtask

    initial begin
        t_reset();
        t_disabled();
        set_len(16'd4);
        t_tie();
        t_equal();
        t_rectify();
        t_gaps();
        t_sticky();
        t_fresh_counts();
        t_collide();
        t_restart();
        finished = 1'b1;
    end

    initial begin
        fork
            begin
                wait (finished);
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule